// File: doc/BRIEF.md
# Fill-Level Clock Steering Byte FIFO

This block is a dual-clock byte FIFO that sits between a byte-wide payload domain and a serial bit stream. Bytes arrive on a write clock whenever a write enable is high. A shift stage in the bit-clock domain takes bytes out of the FIFO and presents one bit on every rising bit-clock edge, most significant bit first.

The block also acts as the phase detector of an external clock-recovery loop. The fill level, as seen from the bit-clock domain, is compared against a programmable high mark and a programmable low mark. The result drives two requests to an external oscillator: one to speed the bit clock up when the buffer is filling, and one to slow it down when the buffer is draining. A write into a full buffer and a read from an empty buffer are each caught by a sticky error flag.

An enable input in the bit-clock domain starts and stops the serial stream. Taking it low and high again is a soft restart. After a restart the shift stage waits for the first byte before it streams, so an empty buffer at start-up is not an error.

Top module: `fifo_clock_steer`

## Requirements
- R1: The buffer holds DEPTH (default 32) bytes. A write is accepted while the write side sees fewer than DEPTH unread bytes. The write side learns of reads, and the bit side learns of writes, through a two-stage Gray-coded pointer synchronizer. A byte written at edge n first counts in bit-side decisions at edge n+3.
- R2: A write made while the write side sees DEPTH unread bytes is dropped, and the bytes already stored are not changed. The drop sets `ovf_flag` at that edge. The flag then stays high until write reset.
- R3: When `run` is high, the shift stage loads a byte at an edge where no bit of a byte is still pending and the bit side sees at least one byte. At that edge `ser_bit` takes bit 7 of the byte. The next seven edges present bits 6 down to 0. A new load is possible on the following edge, so bytes run back to back.
- R4: With `run` high, `speed_up` is registered at each bit-clock edge. It goes high when the fill seen by the bit side before the edge is greater than `mark_hi` and not less than `mark_lo`.
- R5: With `run` high, `slow_down` is registered at each bit-clock edge. It goes high when the seen fill is less than `mark_lo` and not greater than `mark_hi`.
- R6: `speed_up` and `slow_down` are never high together. When neither mark is crossed, or when both are crossed because the marks are inverted, both are low.
- R7: Once a first byte has been loaded since `run` rose, a load slot that finds the buffer empty is an underflow. At that edge `ser_bit` is driven to 0, no byte is consumed, and the load is retried at the next edge. `unf_flag` is set and stays high while `run` stays high.
- R8: At an edge where `run` is low, `ser_bit`, `speed_up`, `slow_down` and `unf_flag` all go to 0, and the bit phase is cleared. After `run` rises, an empty buffer keeps `ser_bit` at 0 without setting `unf_flag` until the first byte is loaded.
- R9: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Byte write clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_en | input | 1 | Write enable for `wr_byte` |
| wr_byte | input | DW (8) | Byte to store |
| bit_clk | input | 1 | Serial bit clock, steered by the loop |
| bit_rst_n | input | 1 | Asynchronous active-low reset, bit domain |
| run | input | 1 | Serial stream enable; a low pulse restarts the stream |
| mark_hi | input | AW (5) | High fill mark |
| mark_lo | input | AW (5) | Low fill mark |
| ser_bit | output | 1 | Serial output bit |
| speed_up | output | 1 | Request to raise the bit-clock rate |
| slow_down | output | 1 | Request to lower the bit-clock rate |
| unf_flag | output | 1 | Sticky underflow flag, bit domain |
| ovf_flag | output | 1 | Sticky overflow flag, write domain |

## Verification
The pointer assertions assume that the two resets are applied together and that each clock is free-running. Without that, a synchronized pointer could lag its source by more than a full buffer, and the fill bound could not hold. The underflow and restart properties assume that `run` and the marks change only between bit-clock edges. The bench drives every input on the falling edge. It runs both domains from one clock, so the three-edge crossing latency is exact and the cycle model can track it. It also takes `run` low only for whole cycles.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic {
      PH_WAIT = 1'b0,
      PH_FLOW = 1'b1
   } stream_phase_e;

   localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/fcs_sync.sv
module fcs_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   import fcs_pkg::*;

   initial begin
      assert (STAGES >= MIN_SYNC_STAGES)
         else $error("fcs_sync: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [W-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_stg[i-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/fcs_byte_store.sv
module fcs_byte_store #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/fcs_wr_side.sv
module fcs_wr_side #(
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [PW-1:0] rgray_s,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [PW-1:0] wgray,
   output logic          ovf_flag
);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] wbin;
   logic [PW-1:0] wbin_nx;
   logic [PW-1:0] rbin_s;
   logic [PW-1:0] seen_fill;
   logic          full;

   assign rbin_s    = g2b(rgray_s);
   assign seen_fill = wbin - rbin_s;
   assign full      = (seen_fill == PW'(DEPTH));
   assign we        = wr_en && !full;
   assign waddr     = wbin[AW-1:0];
   assign wbin_nx   = wbin + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin     <= '0;
         wgray    <= '0;
         ovf_flag <= 1'b0;
      end else begin
         if (we) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
         end
         if (wr_en && full) ovf_flag <= 1'b1;
      end
   end

   // R1: the write side never sees more than DEPTH unread bytes
   a_r1_wr_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      seen_fill <= PW'(DEPTH));

   // R2: a write into a full buffer leaves the write pointer where it was
   a_r2_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> $stable(wgray));

   // R2: the overflow flag holds until reset
   a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

endmodule

// File: rtl/fcs_rd_side.sv
module fcs_rd_side #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1,
   localparam int BW   = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [AW-1:0] mark_hi,
   input  logic [AW-1:0] mark_lo,
   input  logic [PW-1:0] wgray_s,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray,
   output logic          ser_bit,
   output logic          speed_up,
   output logic          slow_down,
   output logic          unf_flag
);
   import fcs_pkg::*;

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0]  rbin;
   logic [PW-1:0]  rbin_nx;
   logic [PW-1:0]  wbin_s;
   logic [PW-1:0]  fill;
   logic [DW-1:0]  shreg;
   logic [BW-1:0]  bit_pos;
   stream_phase_e  phase;
   logic           slot;
   logic           avail;
   logic           above;
   logic           below;

   assign wbin_s  = g2b(wgray_s);
   assign fill    = wbin_s - rbin;
   assign avail   = (fill != '0);
   assign slot    = (bit_pos == '0);
   assign above   = fill > {1'b0, mark_hi};
   assign below   = fill < {1'b0, mark_lo};
   assign raddr   = rbin[AW-1:0];
   assign rbin_nx = rbin + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin      <= '0;
         rgray     <= '0;
         shreg     <= '0;
         bit_pos   <= '0;
         phase     <= PH_WAIT;
         ser_bit   <= 1'b0;
         speed_up  <= 1'b0;
         slow_down <= 1'b0;
         unf_flag  <= 1'b0;
      end else if (!run) begin
         bit_pos   <= '0;
         phase     <= PH_WAIT;
         ser_bit   <= 1'b0;
         speed_up  <= 1'b0;
         slow_down <= 1'b0;
         unf_flag  <= 1'b0;
      end else begin
         speed_up  <= above && !below;
         slow_down <= below && !above;
         if (slot) begin
            if (avail) begin
               ser_bit <= rdata[DW-1];
               shreg   <= {rdata[DW-2:0], 1'b0};
               bit_pos <= BW'(1);
               phase   <= PH_FLOW;
               rbin    <= rbin_nx;
               rgray   <= rbin_nx ^ (rbin_nx >> 1);
            end else begin
               ser_bit <= 1'b0;
               if (phase == PH_FLOW) unf_flag <= 1'b1;
            end
         end else begin
            ser_bit <= shreg[DW-1];
            shreg   <= {shreg[DW-2:0], 1'b0};
            bit_pos <= bit_pos + BW'(1);
         end
      end
   end

   // R1: the bit side never sees more than DEPTH bytes
   a_r1_rd_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= PW'(DEPTH));

   // R7: an empty load slot outputs 0 and keeps the read pointer
   a_r7_unf_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && slot && !avail) |=> (!ser_bit && $stable(rgray)));

   // R7: the underflow flag holds while the stream stays enabled
   a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_flag && run) |=> unf_flag);

   // R8: a disabled edge silences every bit-side output
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!ser_bit && !speed_up && !slow_down && !unf_flag));

   // R3: the read pointer moves only in a load slot
   a_r3_load_only_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !slot) |=> $stable(rgray));

endmodule

// File: rtl/fifo_clock_steer.sv
module fifo_clock_steer #(
   parameter int DEPTH       = 32,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic          wr_clk,
   input  logic          wr_rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_byte,
   input  logic          bit_clk,
   input  logic          bit_rst_n,
   input  logic          run,
   input  logic [AW-1:0] mark_hi,
   input  logic [AW-1:0] mark_lo,
   output logic          ser_bit,
   output logic          speed_up,
   output logic          slow_down,
   output logic          unf_flag,
   output logic          ovf_flag
);

   initial begin
      assert (DEPTH == (1 << AW) && DEPTH >= 4)
         else $error("fifo_clock_steer: DEPTH must be a power of two >= 4");
      assert (DW == (1 << $clog2(DW)) && DW >= 2)
         else $error("fifo_clock_steer: DW must be a power of two >= 2");
   end

   logic          we;
   logic [AW-1:0] waddr;
   logic [AW-1:0] raddr;
   logic [DW-1:0] rdata;
   logic [PW-1:0] wgray;
   logic [PW-1:0] rgray;
   logic [PW-1:0] wgray_s;
   logic [PW-1:0] rgray_s;

   fcs_byte_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk   (wr_clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wr_byte),
      .raddr (raddr),
      .rdata (rdata)
   );

   fcs_wr_side #(.DEPTH(DEPTH)) u_wr (
      .clk      (wr_clk),
      .rst_n    (wr_rst_n),
      .wr_en    (wr_en),
      .rgray_s  (rgray_s),
      .we       (we),
      .waddr    (waddr),
      .wgray    (wgray),
      .ovf_flag (ovf_flag)
   );

   fcs_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk   (bit_clk),
      .rst_n (bit_rst_n),
      .d     (wgray),
      .q     (wgray_s)
   );

   fcs_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk   (wr_clk),
      .rst_n (wr_rst_n),
      .d     (rgray),
      .q     (rgray_s)
   );

   fcs_rd_side #(.DEPTH(DEPTH), .DW(DW)) u_rd (
      .clk       (bit_clk),
      .rst_n     (bit_rst_n),
      .run       (run),
      .mark_hi   (mark_hi),
      .mark_lo   (mark_lo),
      .wgray_s   (wgray_s),
      .rdata     (rdata),
      .raddr     (raddr),
      .rgray     (rgray),
      .ser_bit   (ser_bit),
      .speed_up  (speed_up),
      .slow_down (slow_down),
      .unf_flag  (unf_flag)
   );

endmodule

// File: tb/tb_fifo_clock_steer.sv
`timescale 1ns/1ps
module tb_fifo_clock_steer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       run = 1'b0;
   logic [4:0] mark_hi = 5'd0;
   logic [4:0] mark_lo = 5'd0;
   logic       ser_bit, speed_up, slow_down, unf_flag, ovf_flag;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fifo_clock_steer dut (
      .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
      .bit_clk(clk), .bit_rst_n(rst_n), .run(run),
      .mark_hi(mark_hi), .mark_lo(mark_lo),
      .ser_bit(ser_bit), .speed_up(speed_up), .slow_down(slow_down),
      .unf_flag(unf_flag), .ovf_flag(ovf_flag)
   );

   // behavioural reference model
   bit [7:0] m_q[$];
   int  m_wtot, m_rtot, m_ws1, m_ws2, m_rs1, m_rs2, m_bc;
   bit  m_primed, m_ser, m_up, m_dn, m_unf, m_ovf;
   bit [7:0] m_sh;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         m_wtot = 0; m_rtot = 0; m_ws1 = 0; m_ws2 = 0; m_rs1 = 0; m_rs2 = 0;
         m_bc = 0; m_primed = 0; m_ser = 0; m_up = 0; m_dn = 0;
         m_unf = 0; m_ovf = 0; m_sh = 0;
      end else begin
         int wseen, rseen, cnt, wold, rold;
         bit over, under;
         bit [7:0] b;
         wseen = m_ws2; rseen = m_rs2;
         wold = m_wtot; rold = m_rtot;
         cnt = wseen - m_rtot;
         over = cnt > int'(mark_hi);
         under = cnt < int'(mark_lo);
         if (!run) begin
            m_ser = 0; m_bc = 0; m_primed = 0; m_unf = 0; m_up = 0; m_dn = 0;
         end else begin
            m_up = over && !under;
            m_dn = under && !over;
            if (m_bc == 0) begin
               if (cnt > 0) begin
                  b = m_q.pop_front();
                  m_ser = b[7]; m_sh = {b[6:0], 1'b0};
                  m_bc = 1; m_primed = 1; m_rtot++;
               end else begin
                  m_ser = 0;
                  if (m_primed) m_unf = 1;
               end
            end else begin
               m_ser = m_sh[7]; m_sh = {m_sh[6:0], 1'b0};
               m_bc = (m_bc + 1) % 8;
            end
         end
         if (wr_en) begin
            if (m_wtot - rseen >= 32) m_ovf = 1;
            else begin
               m_q.push_back(wr_byte);
               m_wtot++;
            end
         end
         m_ws2 = m_ws1; m_ws1 = wold;
         m_rs2 = m_rs1; m_rs1 = rold;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(ser_bit == m_ser,     "R3 ser_bit",   ser_bit,   m_ser);
         chk(speed_up == m_up,     "R4 speed_up",  speed_up,  m_up);
         chk(slow_down == m_dn,    "R5 slow_down", slow_down, m_dn);
         chk(unf_flag == m_unf,    "R7 unf_flag",  unf_flag,  m_unf);
         chk(ovf_flag == m_ovf,    "R2 ovf_flag",  ovf_flag,  m_ovf);
         chk(!(speed_up && slow_down), "R6 exclusive", speed_up + slow_down, 1);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en = 1'b0;
      end
   endtask

   task automatic push(input logic [7:0] b, input int gap);
      @(negedge clk);
      wr_en = 1'b1;
      wr_byte = b;
      for (int i = 0; i < gap; i++) begin
         @(negedge clk);
         wr_en = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; run = 1'b0;
      @(negedge clk);
      // R9: reset state
      chk(!ser_bit && !speed_up && !slow_down && !unf_flag && !ovf_flag, "R9 reset outputs",
          {ser_bit, speed_up, slow_down, unf_flag, ovf_flag}, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      idle(3);
      do_reset();

      // R1 / R2: fill to capacity with the stream stopped, then one more
      mark_hi = 5'd20; mark_lo = 5'd4;
      for (int i = 0; i < 32; i++) push(8'(i * 37 + 5), 0);
      idle(6);
      chk(ovf_flag == 1'b0, "R1 32 bytes fit", ovf_flag, 0);
      chk(!speed_up && !slow_down, "R8 steering quiet while stopped", speed_up + slow_down, 0);
      push(8'hEE, 0);
      @(negedge clk);
      wr_en = 1'b0;
      chk(ovf_flag == 1'b1, "R2 overflow flagged", ovf_flag, 1);

      // R3 / R4 / R7: drain the full buffer, then starve it
      @(negedge clk);
      run = 1'b1;
      idle(6);
      chk(speed_up == 1'b1, "R4 full buffer asks for speed", speed_up, 1);
      idle(314);
      chk(unf_flag == 1'b1, "R7 underflow after drain", unf_flag, 1);
      chk(ser_bit == 1'b0, "R7 starved output is 0", ser_bit, 0);
      chk(slow_down == 1'b1, "R5 empty buffer asks for slow", slow_down, 1);

      // R8: soft restart clears and waits for data
      @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      chk(unf_flag == 1'b0 && ser_bit == 1'b0, "R8 restart clears", unf_flag + ser_bit, 0);
      run = 1'b1;
      idle(20);
      chk(unf_flag == 1'b0, "R8 no underflow before first byte", unf_flag, 0);

      // R6: inverted marks, fill between them
      do_reset();
      mark_hi = 5'd3; mark_lo = 5'd10;
      run = 1'b1;
      for (int i = 0; i < 5; i++) push(8'hA5 ^ 8'(i), 0);
      idle(4);
      chk(!speed_up && !slow_down, "R6 both crossed gives neither", speed_up + slow_down, 0);
      idle(60);

      // R3 / R4 / R5: steady stream, first slightly fast then slightly slow
      do_reset();
      mark_hi = 5'd6; mark_lo = 5'd2;
      run = 1'b1;
      for (int i = 0; i < 40; i++) push(8'(i * 91 + 17), 6);
      for (int i = 0; i < 40; i++) push(8'(i * 13 + 200), 8);
      idle(120);

      // R3: back-to-back bursts with walking patterns
      mark_hi = 5'd31; mark_lo = 5'd0;
      for (int i = 0; i < 8; i++) push(8'h01 << i, 0);
      for (int i = 0; i < 8; i++) push(~(8'h01 << i), 3);
      idle(150);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule